// File: doc/BRIEF.md
# Light-Load Burst Mode Controller

This block is the digital supervisor that moves a current-mode power converter into and out of a low-power burst regime. It watches four synchronous flags from feedback-voltage comparators. The low-load flag starts a blanking window. If the flag is still present when the window has run its full length, the block sets its burst flag and turns the internal bias off. Inside a burst, the bias (and so switching) is toggled by a two-level hysteresis. The wake flag turns the bias on and the sleep flag turns it off, so the feedback voltage swings like a sawtooth. A separate exit flag for a higher level ends the burst at once.

While the burst flag is set, a select output chooses the reduced peak current limit. The blanking window is measured in ticks of a parameterised prescaler driven by the system clock. Tests can therefore shorten the millisecond-scale interval. A synchronous reset and an undervoltage-lockout input both return the block to normal operation and clear the blanking count. The comparators, the current-limit references and the gate driver sit outside this block.

Top module: `burst_mode_ctrl`

## Requirements
- R1: After reset, burst_flag is 0, bias_en is 1 and ilim_low_sel is 0.
- R2: Outside a burst, burst entry happens only after fb_lt_low has been 1 on N = CLK_DIV*BLANK_TICKS consecutive clock edges. Any edge with fb_lt_low at 0 restarts the count from zero.
- R3: On the edge that completes the window, burst_flag becomes 1 and bias_en becomes 0 together.
- R4: ilim_low_sel is 1 exactly while burst_flag is 1 (1 selects the reduced current limit).
- R5: In a burst with bias_en at 0, fb_gt_wake at 1 makes bias_en 1 on the next edge.
- R6: In a burst with bias_en at 1, fb_lt_sleep at 1 makes bias_en 0 on the next edge.
- R7: In a burst, fb_gt_exit at 1 makes burst_flag 0, ilim_low_sel 0 and bias_en 1 on the next edge. This takes priority over fb_gt_wake and fb_lt_sleep in the same cycle.
- R8: Outside a burst, fb_gt_wake and fb_lt_sleep have no effect: bias_en stays 1.
- R9: uvlo at 1 forces normal operation on the next edge and clears the blanking count, so a new entry again needs N full edges.
- R10: During a burst, fb_lt_low has no effect on the outputs. After an exit, the blanking count starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| uvlo | input | 1 | Undervoltage lockout, active high |
| fb_lt_low | input | 1 | Feedback below the low-load threshold |
| fb_gt_wake | input | 1 | Feedback above the in-burst wake level |
| fb_lt_sleep | input | 1 | Feedback at or below the in-burst sleep level |
| fb_gt_exit | input | 1 | Feedback above the burst exit level |
| burst_flag | output | 1 | Burst regime active |
| bias_en | output | 1 | Internal bias and switching enabled |
| ilim_low_sel | output | 1 | 1 selects the reduced peak current limit |

## Verification
The blanking window is tried three ways. A low-load run is cut off one edge short, a run lasts exactly the window, and uvlo interrupts a run part way. Between them these separate an off-by-one count, a counter that fails to restart, and a counter that uvlo does not clear. Inside a burst, wake and sleep pulses are alternated and repeated, which shows whether the hysteresis toggles correctly. The exit flag is raised together with sleep or wake, which exposes a wrong priority. Wake and sleep are also pulsed outside a burst, and low-load is held during a burst, to prove that the comparators each state should ignore are in fact ignored.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
   typedef enum logic [1:0] {
      BM_NORMAL    = 2'd0,
      BM_PARKED    = 2'd1,
      BM_SWITCHING = 2'd2
   } bm_state_t;
endpackage

// File: rtl/bmc_prescaler.sv
module bmc_prescaler #(
   parameter int DIV = 1000
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic tick
);
   initial begin
      div_range_chk : assert (DIV >= 1) else $error("DIV must be at least 1");
   end

   generate
      if (DIV == 1) begin : g_bypass
         assign tick = run;
      end else begin : g_count
         localparam int W = $clog2(DIV);
         localparam logic [W-1:0] LAST = W'(DIV - 1);
         logic [W-1:0] cnt;

         always_ff @(posedge clk) begin
            if (rst || !run)      cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
         end

         assign tick = run && (cnt == LAST);

         // R2
         idle_clear_chk : assert property (@(posedge clk) disable iff (rst)
            !run |=> cnt == '0);
      end
   endgenerate
endmodule

// File: rtl/bmc_blank_timer.sv
module bmc_blank_timer #(
   parameter int TICKS = 20
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   input  logic tick,
   output logic expire
);
   localparam int W = (TICKS < 2) ? 1 : $clog2(TICKS);
   localparam logic [W-1:0] LAST = W'(TICKS - 1);

   initial begin
      ticks_range_chk : assert (TICKS >= 2) else $error("TICKS must be at least 2");
   end

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || !run)       cnt <= '0;
      else if (tick) begin
         if (cnt == LAST)    cnt <= '0;
         else                cnt <= cnt + 1'b1;
      end
   end

   assign expire = tick && (cnt == LAST);

   // R2
   expire_needs_run_chk : assert property (@(posedge clk) disable iff (rst)
      expire |-> run);

   // R9
   restart_chk : assert property (@(posedge clk) disable iff (rst)
      !run |=> cnt == '0);
endmodule

// File: rtl/bmc_mode_fsm.sv
module bmc_mode_fsm
   import bmc_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      uvlo,
   input  logic      expire,
   input  logic      wake,
   input  logic      sleep,
   input  logic      exit_req,
   output bm_state_t state
);
   bm_state_t nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         BM_NORMAL:    if (expire) nxt = BM_PARKED;
         BM_PARKED:    if (exit_req) nxt = BM_NORMAL;
                       else if (wake) nxt = BM_SWITCHING;
         BM_SWITCHING: if (exit_req) nxt = BM_NORMAL;
                       else if (sleep) nxt = BM_PARKED;
         default:      nxt = BM_NORMAL;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst || uvlo) state <= BM_NORMAL;
      else             state <= nxt;
   end

   // R7
   exit_prio_chk : assert property (@(posedge clk) disable iff (rst)
      (state != BM_NORMAL && exit_req) |=> state == BM_NORMAL);

   // R5
   wake_chk : assert property (@(posedge clk) disable iff (rst)
      (state == BM_PARKED && wake && !exit_req && !uvlo) |=> state == BM_SWITCHING);

   // R6
   sleep_chk : assert property (@(posedge clk) disable iff (rst)
      (state == BM_SWITCHING && sleep && !exit_req && !uvlo) |=> state == BM_PARKED);

   // R9
   uvlo_clear_chk : assert property (@(posedge clk) disable iff (rst)
      uvlo |=> state == BM_NORMAL);

   // R3
   entry_source_chk : assert property (@(posedge clk) disable iff (rst)
      (state == BM_NORMAL && !expire) |=> state == BM_NORMAL);
endmodule

// File: rtl/burst_mode_ctrl.sv
module burst_mode_ctrl
   import bmc_pkg::*;
#(
   parameter int CLK_DIV     = 1000,
   parameter int BLANK_TICKS = 20
) (
   input  logic clk,
   input  logic rst,
   input  logic uvlo,
   input  logic fb_lt_low,
   input  logic fb_gt_wake,
   input  logic fb_lt_sleep,
   input  logic fb_gt_exit,
   output logic burst_flag,
   output logic bias_en,
   output logic ilim_low_sel
);
   bm_state_t state;
   logic      count_run;
   logic      tick;
   logic      expire;
   logic      timer_rst;

   assign timer_rst = rst || uvlo;
   assign count_run = (state == BM_NORMAL) && fb_lt_low && !uvlo;

   bmc_prescaler #(.DIV(CLK_DIV)) u_presc (
      .clk  (clk),
      .rst  (timer_rst),
      .run  (count_run),
      .tick (tick)
   );

   bmc_blank_timer #(.TICKS(BLANK_TICKS)) u_blank (
      .clk    (clk),
      .rst    (timer_rst),
      .run    (count_run),
      .tick   (tick),
      .expire (expire)
   );

   bmc_mode_fsm u_fsm (
      .clk      (clk),
      .rst      (rst),
      .uvlo     (uvlo),
      .expire   (expire),
      .wake     (fb_gt_wake),
      .sleep    (fb_lt_sleep),
      .exit_req (fb_gt_exit),
      .state    (state)
   );

   assign burst_flag   = (state != BM_NORMAL);
   assign bias_en      = (state != BM_PARKED);
   assign ilim_low_sel = burst_flag;

   // R3
   entry_bias_off_chk : assert property (@(posedge clk) disable iff (rst)
      $rose(burst_flag) |-> !bias_en);

   // R8
   normal_bias_chk : assert property (@(posedge clk) disable iff (rst)
      (!burst_flag && !expire) |=> bias_en);
endmodule

// File: tb/burst_mode_ctrl_test.sv
module burst_mode_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int DIV   = 4;
   localparam int TICKS = 5;
   localparam int N     = DIV * TICKS;

   logic clk = 1'b0;
   logic rst = 1'b1, uvlo = 1'b0;
   logic lo = 1'b0, wk = 1'b0, sl = 1'b0, ex = 1'b0;
   logic burst_flag, bias_en, ilim_low_sel;

   int n_cmp  = 0;
   int n_bad  = 0;
   int m_mode = 0;   // 0 normal, 1 burst parked, 2 burst switching
   int m_run  = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_mode_ctrl #(.CLK_DIV(DIV), .BLANK_TICKS(TICKS)) uut (
      .clk(clk), .rst(rst), .uvlo(uvlo), .fb_lt_low(lo), .fb_gt_wake(wk),
      .fb_lt_sleep(sl), .fb_gt_exit(ex), .burst_flag(burst_flag),
      .bias_en(bias_en), .ilim_low_sel(ilim_low_sel)
   );

   task automatic step(input logic r, input logic u, input logic l,
                       input logic w, input logic s, input logic e,
                       input string tag);
      logic eb, ei, ebias;
      rst = r; uvlo = u; lo = l; wk = w; sl = s; ex = e;
      if (r || u) begin
         m_mode = 0; m_run = 0;
      end else if (m_mode == 0) begin
         if (l) begin
            m_run++;
            if (m_run == N) begin m_mode = 1; m_run = 0; end
         end else m_run = 0;
      end else if (e) begin
         m_mode = 0; m_run = 0;
      end else if (m_mode == 1 && w) m_mode = 2;
      else if (m_mode == 2 && s) m_mode = 1;
      @(posedge clk);
      @(negedge clk);
      eb = (m_mode != 0); ei = eb; ebias = (m_mode != 1);
      n_cmp++;
      if (burst_flag !== eb || ilim_low_sel !== ei || bias_en !== ebias) begin
         n_bad++;
         $display("FAIL %s: got flag=%b ilim=%b bias=%b expected flag=%b ilim=%b bias=%b",
                  tag, burst_flag, ilim_low_sel, bias_en, eb, ei, ebias);
      end
   endtask

   task automatic enter_burst(input string tag);
      for (int i = 0; i < N; i++) step(0, 0, 1, 0, 0, 0, tag);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      step(1, 0, 0, 0, 0, 0, "R1 reset");
      step(1, 0, 1, 1, 0, 0, "R1 reset");
      // R8: hysteresis flags outside a burst
      step(0, 0, 0, 1, 0, 0, "R8 wake ignored");
      step(0, 0, 0, 0, 1, 0, "R8 sleep ignored");
      step(0, 0, 0, 1, 1, 1, "R8 all ignored");
      // R2: one edge short, then gap
      for (int i = 0; i < N - 1; i++) step(0, 0, 1, 0, 0, 0, "R2 short run");
      step(0, 0, 0, 0, 0, 0, "R2 gap");
      for (int i = 0; i < N - 1; i++) step(0, 0, 1, 1, 0, 0, "R2 restart");
      step(0, 0, 1, 0, 0, 0, "R3 entry");
      // R10: low ignored inside burst; R4 limit select
      for (int i = 0; i < 6; i++) step(0, 0, 1, 0, 0, 0, "R10 low in burst R4");
      // R5 / R6 hysteresis
      step(0, 0, 0, 1, 0, 0, "R5 wake");
      step(0, 0, 0, 1, 0, 0, "R5 wake held");
      step(0, 0, 0, 0, 1, 0, "R6 sleep");
      step(0, 0, 0, 0, 1, 0, "R6 sleep held");
      step(0, 0, 0, 1, 0, 0, "R5 wake again");
      step(0, 0, 0, 0, 1, 0, "R6 sleep again");
      // R7 exit with sleep, from parked state with wake
      step(0, 0, 0, 1, 0, 0, "R5 wake");
      step(0, 0, 0, 0, 1, 1, "R7 exit over sleep");
      enter_burst("R10 recount");
      step(0, 0, 0, 1, 0, 1, "R7 exit over wake");
      // R9 uvlo mid-count and mid-burst
      for (int i = 0; i < N - 2; i++) step(0, 0, 1, 0, 0, 0, "R9 count");
      step(0, 0, 1, 0, 0, 0, "R9 uvlo");
      step(0, 1, 1, 0, 0, 0, "R9 uvlo");
      for (int i = 0; i < N - 1; i++) step(0, 0, 1, 0, 0, 0, "R9 recount");
      step(0, 0, 1, 0, 0, 0, "R9 entry");
      step(0, 0, 0, 1, 0, 0, "R5 wake");
      step(0, 1, 0, 0, 0, 0, "R9 uvlo burst");
      step(0, 0, 0, 0, 0, 0, "R9 after");
      step(1, 0, 0, 0, 0, 0, "R1 final reset");
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule